// File: doc/BRIEF.md
# Operand Address Generator

This block forms the storage address of an instruction operand from three fields taken from the instruction: a 4-bit base register selector, a 4-bit index register selector and a 12-bit displacement. It holds a file of sixteen 32-bit general registers. Two combinational read ports fetch the base and index values. The block adds the selected values to the displacement and returns a 24-bit address one clock after a start strobe, together with a valid strobe.

A selector value of zero stands for "no register". That term then adds zero, whatever register 0 holds. Register values are treated as two's-complement numbers, so a negative index moves the address downward. The sum is cut to its low 24 bits, and no overflow is reported. For every address it produces, the block also checks alignment against a requested operand width and raises a misalignment flag when the address is not a multiple of that width. A write port loads the register file; a write becomes visible after the next clock edge.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `addr_valid`, `addr_out` and `misalign` are all zero until the first start.
- R2: `addr_valid` is high in exactly the cycle after a cycle with `start` high, and low in every other cycle.
- R3: `addr_out` equals (base value + index value + displacement) mod 2^24. Register bits above bit 23 and any carry out of bit 23 have no effect on the result.
- R4: A base or index selector of 0 adds zero, even when register 0 holds a nonzero value.
- R5: The displacement is unsigned: a field of 0xFFF adds 4095.
- R6: Register values are two's complement, so an index of 0xFFFFFFF0 lowers the address by 16.
- R7: `op_size` encodes 0 = byte, 1 = half (2 bytes), 2 = full (4 bytes), 3 = double (8 bytes). `misalign` is high with the result when the address is not a multiple of that width. A byte request never flags.
- R8: A register write (`wr_en`, `wr_sel`, `wr_data`) takes effect at the clock edge that samples it. A start in a later cycle uses the new value.
- R9: In cycles without `start`, `addr_out` and `misalign` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register file write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Value to write |
| start | input | 1 | Begin an address computation |
| base_sel | input | 4 | Base register number, 0 = none |
| index_sel | input | 4 | Index register number, 0 = none |
| disp | input | 12 | Unsigned displacement |
| op_size | input | 2 | Operand width code for the alignment check |
| addr_out | output | 24 | Effective address |
| addr_valid | output | 1 | High for one cycle when `addr_out` is new |
| misalign | output | 1 | Alignment fault for the requested width |

## Verification
The bench loads register 0 with a nonzero pattern. A design that reads register 0 for a zero selector then returns a wrong address. Some sums carry past bit 23, some register values have bits set above bit 23, and one index is negative. A design that widens the result, lets upper bits leak in, or extends the index wrongly is caught on these cases. The displacement 0xFFF catches a design that sign-extends the displacement. Odd and part-aligned addresses under each width code catch a wrong alignment mask. A start issued right after a write shows whether the write reaches the register file in time.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int REGS    = 16,
  parameter int RW      = 32,
  parameter int AW      = 24,
  parameter int DW      = 12,
  localparam int SELW   = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [RW-1:0]   wr_data,
  input  logic            start,
  input  logic [SELW-1:0] base_sel,
  input  logic [SELW-1:0] index_sel,
  input  logic [DW-1:0]   disp,
  input  logic [1:0]      op_size,
  output logic [AW-1:0]   addr_out,
  output logic            addr_valid,
  output logic            misalign
);

  logic [RW-1:0] gpr [REGS];
  logic [AW-1:0] base_term, index_term, sum;
  logic [2:0]    low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) gpr[i] <= '0;
    end else if (wr_en) begin
      gpr[wr_sel] <= wr_data;
    end
  end

  assign base_term  = (base_sel  == '0) ? '0 : gpr[base_sel][AW-1:0];
  assign index_term = (index_sel == '0) ? '0 : gpr[index_sel][AW-1:0];
  assign sum        = base_term + index_term + AW'(disp);

  always_comb begin
    case (op_size)
      2'd0:    low_mask = 3'b000;
      2'd1:    low_mask = 3'b001;
      2'd2:    low_mask = 3'b011;
      default: low_mask = 3'b111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
      misalign   <= 1'b0;
    end else begin
      addr_valid <= start;
      if (start) begin
        addr_out <= sum;
        misalign <= |(sum[2:0] & low_mask);
      end
    end
  end

endmodule

module opnd_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  base_sel,
  input logic [3:0]  index_sel,
  input logic [11:0] disp,
  input logic [1:0]  op_size,
  input logic [23:0] addr_out,
  input logic        addr_valid,
  input logic        misalign
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!addr_valid && !misalign && addr_out == 24'd0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !addr_valid);

  assert_zero_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && base_sel == 4'd0 && index_sel == 4'd0) |=> addr_out == {12'd0, $past(disp)});

  assert_byte_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_size == 2'd0) |=> !misalign);

  assert_flag_has_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (addr_out[2:0] != 3'd0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(addr_out) && $stable(misalign)));

endmodule

bind opnd_addr_gen opnd_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base_sel(base_sel),
  .index_sel(index_sel), .disp(disp), .op_size(op_size),
  .addr_out(addr_out), .addr_valid(addr_valid), .misalign(misalign)
);

// File: tb/opnd_addr_gen_test.sv
module opnd_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic [3:0]  base_sel = '0;
  logic [3:0]  index_sel = '0;
  logic [11:0] disp = '0;
  logic [1:0]  op_size = '0;
  logic [23:0] addr_out;
  logic        addr_valid;
  logic        misalign;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  opnd_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .base_sel(base_sel), .index_sel(index_sel), .disp(disp),
    .op_size(op_size), .addr_out(addr_out), .addr_valid(addr_valid), .misalign(misalign)
  );

  // {base, index, disp, size, expected addr, expected flag, requirement}
  localparam int NV = 14;
  localparam logic [50:0] VEC [NV] = '{
    {4'd0, 4'd0, 12'h123, 2'd0, 24'h000123, 1'b0, 4'd4}, // R4
    {4'd1, 4'd0, 12'h010, 2'd2, 24'h001010, 1'b0, 4'd3}, // R3
    {4'd1, 4'd5, 12'h001, 2'd3, 24'h001004, 1'b1, 4'd7}, // R7
    {4'd2, 4'd0, 12'h020, 2'd0, 24'h000010, 1'b0, 4'd3}, // R3 carry out of bit 23
    {4'd1, 4'd3, 12'h000, 2'd2, 24'h000FF0, 1'b0, 4'd6}, // R6
    {4'd0, 4'd3, 12'h000, 2'd0, 24'hFFFFF0, 1'b0, 4'd6}, // R6 with base none
    {4'd1, 4'd0, 12'hFFF, 2'd0, 24'h001FFF, 1'b0, 4'd5}, // R5
    {4'd1, 4'd0, 12'hFFF, 2'd1, 24'h001FFF, 1'b1, 4'd7}, // R7 half odd
    {4'd4, 4'd0, 12'h000, 2'd2, 24'h000004, 1'b0, 4'd3}, // R3 upper bits dropped
    {4'd5, 4'd0, 12'h000, 2'd1, 24'h000003, 1'b1, 4'd7}, // R7
    {4'd6, 4'd5, 12'h002, 2'd3, 24'h00000C, 1'b1, 4'd7}, // R7 double
    {4'd0, 4'd1, 12'h000, 2'd3, 24'h001000, 1'b0, 4'd4}, // R4 index only
    {4'd7, 4'd7, 12'hFFF, 2'd2, 24'h000FFD, 1'b1, 4'd3}, // R3 wrap
    {4'd1, 4'd0, 12'h006, 2'd2, 24'h001006, 1'b1, 4'd7}  // R7 full
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [3:0] r, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = r; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic [3:0] b, input logic [3:0] x, input logic [11:0] d,
                       input logic [1:0] s);
    @(negedge clk);
    base_sel = b; index_sel = x; disp = d; op_size = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", {addr_valid, misalign, addr_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {addr_valid, misalign, addr_out}, 32'd0);

    write_reg(4'd0, 32'h12345678);
    write_reg(4'd1, 32'h00001000);
    write_reg(4'd2, 32'h00FFFFF0);
    write_reg(4'd3, 32'hFFFFFFF0);
    write_reg(4'd4, 32'h01000004);
    write_reg(4'd5, 32'h00000003);
    write_reg(4'd6, 32'h00000007);
    write_reg(4'd7, 32'h7FFFFFFF);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][50:47], VEC[i][46:43], VEC[i][42:31], VEC[i][30:29]);
      check($sformatf("R%0d vec%0d addr", VEC[i][3:0], i), {8'd0, addr_out}, {8'd0, VEC[i][28:5]});
      check($sformatf("R%0d vec%0d flag", VEC[i][3:0], i), {31'd0, misalign}, {31'd0, VEC[i][4]});
      check("R2 valid", {31'd0, addr_valid}, 32'd1);
    end

    // R2: valid drops in the next idle cycle
    @(negedge clk);
    check("R2 idle", {31'd0, addr_valid}, 32'd0);

    // R9: change operands with start low, results hold
    base_sel = 4'd7; index_sel = 4'd6; disp = 12'h001; op_size = 2'd0;
    repeat (2) @(negedge clk);
    check("R9 addr", {8'd0, addr_out}, 32'h001006);
    check("R9 flag", {31'd0, misalign}, 32'd1);

    // R8: write then start in the very next cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd1; wr_data = 32'h00ABC000;
    @(negedge clk);
    wr_en = 1'b0;
    base_sel = 4'd1; index_sel = 4'd0; disp = 12'h008; op_size = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 addr", {8'd0, addr_out}, 32'h00ABC008);
    check("R8 flag", {31'd0, misalign}, 32'd0);

    // R1: reset in mid run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rerun", {addr_valid, misalign, addr_out}, 32'd0);
    rst_n = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule